// File: doc/BRIEF.md
# Fractional Baud-Rate Tick Generator

This block produces the oversampling tick that paces a serial transmitter and receiver. The module clock first passes through an integer pre-divider, programmable from 1 to 8. The pre-divided rate is then divided by a fixed-point divisor with a 16-bit whole part and a 6-bit fraction. As a result, the tick rate equals the oversampling factor times the baud rate. Alongside the tick, the block emits a one-cycle bit-boundary strobe on every Nth tick, where N is the selected oversampling factor (16, 8 or 3).

Software computes the divisor. The whole part is the pre-divided clock divided by (oversampling × baud). The fraction field is that quotient's fractional part times 64, rounded to nearest by adding one half before truncation. For example, a 40 MHz clock with pre-divide 1, 16× oversampling and 19200 baud gives a whole part of 130 and a fraction of 13.

The configuration is loaded through three simple write strobes. It can change only while the block is disabled. The fraction is realised with a 6-bit phase accumulator: each tick period whose accumulation carries is one pre-divided clock longer.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, `tick` and `bitStrobe` are low, and the configuration is pre-divide 1, whole part 0, fraction 0, 16× oversampling. Enabling in that state produces no ticks.
- R2: The `preDivData` value p (0..7) selects a pre-divide ratio of p+1. Every tick interval is counted in units of p+1 module clocks.
- R3: With fraction 0 and whole part I ≥ 1, the k-th tick after enable rises (p+1)·k·I clock edges after the first enabled edge, with one register stage included.
- R4: With whole part I ≥ 1 and fraction F, the k-th tick appears at edge (p+1)·(k·I + floor(k·F/64)), counted from the first enabled edge. This holds for divisor values derived with the round-half-up rule, such as 130/13.
- R5: A whole part of 0 produces no ticks and no bit strobes, whatever the fraction.
- R6: The `ovsData` code selects the oversampling factor N: 2'b00 gives 16, 2'b01 gives 8, 2'b10 gives 3, and 2'b11 gives 16. `bitStrobe` is high together with every Nth tick and at no other time.
- R7: While `altCoding` is high, the 3× code (2'b10) acts as 8×.
- R8: Configuration writes presented while `enable` is high are ignored. The running tick and bit-strobe pattern stays unchanged.
- R9: When `enable` goes from 0 to 1, the tick phase, fraction accumulator and oversampling count restart from zero. When `enable` is low at a clock edge, `tick` and `bitStrobe` are low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run control; configuration can be written only while low |
| wrPrediv | input | 1 | Write strobe for the pre-divide field |
| preDivData | input | 3 | Pre-divide ratio minus one |
| wrDivisor | input | 1 | Write strobe for whole part and fraction |
| intData | input | 16 | Whole part of the divisor |
| fracData | input | 6 | Fraction of the divisor in 1/64 units |
| wrOvs | input | 1 | Write strobe for the oversampling code |
| ovsData | input | 2 | Oversampling code |
| altCoding | input | 1 | High when a line coding that forbids 3× oversampling is active |
| tick | output | 1 | One-cycle oversampling tick |
| bitStrobe | output | 1 | One-cycle strobe on the last tick of each bit |

## Verification
A wrong accumulator value would not stop the block. It would shift the tick positions by whole pre-divided clocks. The error would show at the first tick whose carry pattern differs, at most 64 tick periods after enable. For that reason, every enabled cycle is compared with an exact model of tick positions, not only the average rate. A stuck or misloaded oversampling counter would misplace `bitStrobe` within one bit time. A configuration register that accepted a write while enabled would change the tick spacing at the very next interval.

// File: rtl/baud_tick_pkg.sv
`timescale 1ns/1ps
package baud_tick_pkg;
  localparam int OVS_W = 4;

  typedef enum logic [1:0] {
    OVS_16  = 2'b00,
    OVS_8   = 2'b01,
    OVS_3   = 2'b10,
    OVS_16B = 2'b11
  } ovsSel_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic run;    // divisor valid and block enabled
    logic clear;  // hold every counter at zero
  } tickCtl_t;
endpackage

// File: rtl/baud_tick_ctrl.sv
`timescale 1ns/1ps
module baud_tick_ctrl
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int PRE_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    enable,
  input  logic                    wrPrediv,
  input  logic [PRE_W-1:0]        preDivData,
  input  logic                    wrDivisor,
  input  logic [INT_W-1:0]        intData,
  input  logic [FRAC_W-1:0]       fracData,
  input  logic                    wrOvs,
  input  logic [1:0]              ovsData,
  input  logic                    altCoding,
  output tickCtl_t                ctl,
  output logic [PRE_W-1:0]        preLimit,
  output logic [INT_W-1:0]        divInt,
  output logic [FRAC_W-1:0]       divFrac,
  output logic [OVS_W-1:0]        ovsLast
);
  ovsSel_t ovsReg;

  // Configuration only loads while the block is stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preLimit <= '0;
      divInt   <= '0;
      divFrac  <= '0;
      ovsReg   <= OVS_16;
    end else if (!enable) begin
      if (wrPrediv) preLimit <= preDivData;
      if (wrDivisor) begin
        divInt  <= intData;
        divFrac <= fracData;
      end
      if (wrOvs) ovsReg <= ovsSel_t'(ovsData);
    end
  end

  // Last index of the oversampling count; 3x falls back to 8x under alt coding
  always_comb begin
    case (ovsReg)
      OVS_8:   ovsLast = OVS_W'(7);
      OVS_3:   ovsLast = altCoding ? OVS_W'(7) : OVS_W'(2);
      default: ovsLast = OVS_W'(15);
    endcase
  end

  always_comb begin
    ctl.clear = ~enable;
    ctl.run   = enable && (divInt != '0);
  end
endmodule

// File: rtl/baud_tick_datapath.sv
`timescale 1ns/1ps
module baud_tick_datapath
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tickCtl_t          ctl,
  input  logic [PRE_W-1:0]  preLimit,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic [OVS_W-1:0]  ovsLast,
  output logic              tick,
  output logic              bitStrobe
);
  logic [PRE_W-1:0]  preCnt;
  logic [INT_W-1:0]  divCnt;
  logic [FRAC_W-1:0] acc;
  logic [OVS_W-1:0]  ovsCnt;
  logic [FRAC_W:0]   accSum;
  logic              stretch;
  logic              preEn;
  logic              atEnd;
  logic              fire;
  logic              bitEnd;

  always_comb begin
    accSum  = {1'b0, acc} + {1'b0, divFrac};
    stretch = accSum[FRAC_W];
    preEn   = ctl.run && (preCnt == preLimit);
    atEnd   = stretch ? (divCnt == divInt)
                      : (divCnt == divInt - {{(INT_W-1){1'b0}}, 1'b1});
    fire    = preEn && atEnd;
    bitEnd  = (ovsCnt >= ovsLast);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt    <= '0;
      divCnt    <= '0;
      acc       <= '0;
      ovsCnt    <= '0;
      tick      <= 1'b0;
      bitStrobe <= 1'b0;
    end else if (ctl.clear) begin
      preCnt    <= '0;
      divCnt    <= '0;
      acc       <= '0;
      ovsCnt    <= '0;
      tick      <= 1'b0;
      bitStrobe <= 1'b0;
    end else begin
      tick      <= fire;
      bitStrobe <= fire && bitEnd;
      if (ctl.run) preCnt <= preEn ? '0 : preCnt + 1'b1;
      if (preEn) begin
        if (atEnd) begin
          divCnt <= '0;
          acc    <= accSum[FRAC_W-1:0];
        end else begin
          divCnt <= divCnt + 1'b1;
        end
      end
      if (fire) ovsCnt <= bitEnd ? '0 : ovsCnt + 1'b1;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
`timescale 1ns/1ps
module baud_tick_gen
  import baud_tick_pkg::*;
#(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6,
  parameter int PRE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              wrPrediv,
  input  logic [PRE_W-1:0]  preDivData,
  input  logic              wrDivisor,
  input  logic [INT_W-1:0]  intData,
  input  logic [FRAC_W-1:0] fracData,
  input  logic              wrOvs,
  input  logic [1:0]        ovsData,
  input  logic              altCoding,
  output logic              tick,
  output logic              bitStrobe
);
  tickCtl_t          ctl;
  logic [PRE_W-1:0]  cfgPre;
  logic [INT_W-1:0]  cfgInt;
  logic [FRAC_W-1:0] cfgFrac;
  logic [OVS_W-1:0]  cfgOvsLast;

  baud_tick_ctrl #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .wrPrediv(wrPrediv), .preDivData(preDivData),
    .wrDivisor(wrDivisor), .intData(intData), .fracData(fracData),
    .wrOvs(wrOvs), .ovsData(ovsData), .altCoding(altCoding),
    .ctl(ctl), .preLimit(cfgPre), .divInt(cfgInt), .divFrac(cfgFrac),
    .ovsLast(cfgOvsLast)
  );

  baud_tick_datapath #(.INT_W(INT_W), .FRAC_W(FRAC_W), .PRE_W(PRE_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .ctl(ctl),
    .preLimit(cfgPre), .divInt(cfgInt), .divFrac(cfgFrac),
    .ovsLast(cfgOvsLast), .tick(tick), .bitStrobe(bitStrobe)
  );
endmodule

// File: rtl/baud_tick_checker.sv
`timescale 1ns/1ps
module baud_tick_checker #(
  parameter int INT_W  = 16,
  parameter int FRAC_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              wrDivisor,
  input logic              tick,
  input logic              bitStrobe,
  input logic [INT_W-1:0]  divInt,
  input logic [FRAC_W-1:0] divFrac
);
  p_strobe_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bitStrobe |-> tick);

  p_stop_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!tick && !bitStrobe));

  p_zero_int_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (divInt == '0) |-> (!tick && !bitStrobe));

  p_locked_divisor_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && wrDivisor) |=> ($stable(divInt) && $stable(divFrac)));
endmodule

bind baud_tick_gen baud_tick_checker #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .wrDivisor(wrDivisor),
  .tick(tick), .bitStrobe(bitStrobe), .divInt(cfgInt), .divFrac(cfgFrac)
);

// File: tb/baud_tick_gen_bench.sv
`timescale 1ns/1ps
module baud_tick_gen_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        wrPrediv = 1'b0;
  logic [2:0]  preDivData = '0;
  logic        wrDivisor = 1'b0;
  logic [15:0] intData = '0;
  logic [5:0]  fracData = '0;
  logic        wrOvs = 1'b0;
  logic [1:0]  ovsData = '0;
  logic        altCoding = 1'b0;
  logic        tick;
  logic        bitStrobe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  baud_tick_gen u_baud_tick_gen (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .wrPrediv(wrPrediv), .preDivData(preDivData),
    .wrDivisor(wrDivisor), .intData(intData), .fracData(fracData),
    .wrOvs(wrOvs), .ovsData(ovsData), .altCoding(altCoding),
    .tick(tick), .bitStrobe(bitStrobe)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ovsN(input int code, input bit alt);
    if (code == 1) return 8;
    if (code == 2) return alt ? 8 : 3;
    return 16;
  endfunction

  // Edge index of the k-th tick
  function automatic longint tickTime(input int k, input int r, input int i, input int f);
    return longint'(r) * (longint'(k) * i + (longint'(k) * f) / 64);
  endfunction

  // Divisor value times 64, rounded half up
  function automatic longint brdX64(input longint fclk, input longint div,
                                    input longint ovs, input longint baud);
    longint q;
    q = (fclk * 128) / (div * ovs * baud);
    return (q + 1) / 2;
  endfunction

  task automatic configure(input int p, input int i, input int f, input int o, input bit alt);
    @(negedge clk);
    preDivData = 3'(p); intData = 16'(i); fracData = 6'(f); ovsData = 2'(o);
    wrPrediv = 1'b1; wrDivisor = 1'b1; wrOvs = 1'b1; altCoding = alt;
    @(negedge clk);
    wrPrediv = 1'b0; wrDivisor = 1'b0; wrOvs = 1'b0;
  endtask

  // Enables the block and compares every cycle against the tick model
  task automatic runMeasure(input int cycles, input int r, input int i, input int f,
                            input int n, input bit poke, input string req);
    int k = 1;
    int errs = 0;
    longint nextT;
    longint badJ = 0;
    longint badV = 0;
    bit expTick;
    bit expBit;
    nextT = (i == 0) ? -1 : tickTime(1, r, i, f);
    @(negedge clk);
    enable = 1'b1;
    for (int j = 1; j <= cycles; j++) begin
      @(posedge clk);
      #1;
      expTick = (j == nextT);
      expBit = expTick && ((k % n) == 0);
      if (expTick) begin
        k++;
        nextT = tickTime(k, r, i, f);
      end
      if (tick !== expTick || bitStrobe !== expBit) begin
        if (errs == 0) begin
          badJ = j;
          badV = {tick, bitStrobe};
        end
        errs++;
      end
      if (poke && j == 3) begin
        intData = 16'd2; fracData = 6'd40; ovsData = 2'd2; preDivData = 3'd0;
        wrDivisor = 1'b1; wrOvs = 1'b1; wrPrediv = 1'b1;
      end
      if (poke && j == 4) begin
        wrDivisor = 1'b0; wrOvs = 1'b0; wrPrediv = 1'b0;
      end
    end
    if (errs != 0) $display("  mismatch at edge %0d, {tick,bitStrobe}=%0d", badJ, badV);
    check(errs == 0, req, errs, 0);
  endtask

  task automatic stopAndCheck(input string req);
    int bad = 0;
    @(negedge clk);
    enable = 1'b0;
    for (int j = 0; j < 5; j++) begin
      @(posedge clk);
      #1;
      if (tick !== 1'b0 || bitStrobe !== 1'b0) bad++;
    end
    check(bad == 0, req, bad, 0);
  endtask

  initial begin
    longint v;
    int p, i, f, o;
    bit alt;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check(tick === 1'b0, "R1 tick after reset", tick, 0);
    check(bitStrobe === 1'b0, "R1 bitStrobe after reset", bitStrobe, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: default divisor is zero, so enabling gives silence
    runMeasure(200, 1, 0, 0, 16, 1'b0, "R1 default config silent");
    stopAndCheck("R9 stop after default run");

    // R3: whole part only, 8x
    configure(0, 4, 0, 1, 1'b0);
    runMeasure(200, 1, 4, 0, 8, 1'b0, "R3 integer divisor");
    stopAndCheck("R9 stop after R3 run");

    // R2: largest pre-divide
    configure(7, 3, 0, 0, 1'b0);
    runMeasure(900, 8, 3, 0, 16, 1'b0, "R2 pre-divide by 8");
    stopAndCheck("R9 stop after R2 run");

    // R5: zero whole part with nonzero fraction
    configure(0, 0, 50, 2, 1'b0);
    runMeasure(300, 1, 0, 50, 3, 1'b0, "R5 zero whole part");
    stopAndCheck("R9 stop after R5 run");

    // R6: 3x code and reserved code
    configure(0, 2, 0, 2, 1'b0);
    runMeasure(120, 1, 2, 0, 3, 1'b0, "R6 3x oversampling");
    stopAndCheck("R9 stop after R6 3x run");
    configure(1, 1, 0, 3, 1'b0);
    runMeasure(140, 2, 1, 0, 16, 1'b0, "R6 code 3 acts as 16x");
    stopAndCheck("R9 stop after R6 code-3 run");

    // R7: alt coding turns 3x into 8x
    configure(0, 2, 0, 2, 1'b1);
    runMeasure(120, 1, 2, 0, 8, 1'b0, "R7 3x falls back to 8x");
    stopAndCheck("R9 stop after R7 run");
    altCoding = 1'b0;

    // R4: worked divisor example from 40 MHz, 19200 baud, 16x
    v = brdX64(64'd40000000, 64'd1, 64'd16, 64'd19200);
    check(v == 64'd8333, "R4 divisor rounding", v, 8333);
    configure(0, int'(v >> 6), int'(v & 63), 0, 1'b0);
    runMeasure(4300, 1, 130, 13, 16, 1'b0, "R4 fractional 130/13");
    stopAndCheck("R9 stop after R4 run");

    // R8: writes while running are ignored
    configure(1, 5, 21, 1, 1'b0);
    runMeasure(600, 2, 5, 21, 8, 1'b1, "R8 writes ignored while enabled");
    stopAndCheck("R9 stop after R8 run");

    // R9: restart mid-period begins from zero phase
    configure(2, 7, 45, 1, 1'b0);
    runMeasure(53, 3, 7, 45, 8, 1'b0, "R9 partial run");
    stopAndCheck("R9 stop mid-period");
    runMeasure(700, 3, 7, 45, 8, 1'b0, "R9 restart from zero phase");
    stopAndCheck("R9 stop after restart");

    // R4 and R2: random configurations
    for (int t = 0; t < 20; t++) begin
      p = int'($urandom_range(0, 7));
      i = int'($urandom_range(1, 20));
      f = int'($urandom_range(0, 63));
      o = int'($urandom_range(0, 3));
      alt = 1'($urandom_range(0, 1));
      configure(p, i, f, o, alt);
      runMeasure((p + 1) * (i + 1) * 12, p + 1, i, f, ovsN(o, alt), 1'b0, "R4 random config");
      stopAndCheck("R9 stop after random run");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #750000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule